// File: doc/BRIEF.md
# Clock Speed Mode and ALE Generator

This block turns a free-running oscillator clock into a one-cycle core clock enable for an 8-bit controller core. In standard speed the oscillator is first halved, so the core advances on every second oscillator cycle and a machine cycle spans twelve oscillator periods. In double speed the halving stage is bypassed, the enable is high on every oscillator cycle, and a machine cycle spans six oscillator periods. A single speed bit chooses between the two. A new value of that bit is accepted only when the halved clock is about to rise, so the enable stream never breaks up while the speed changes.

The block counts core steps through six states per machine cycle and outputs that count. It also produces the address latch strobe. The strobe fires on state 0 and on state 3 of each machine cycle. This gives one strobe every six oscillator periods in standard speed and one every three in double speed. A suppress bit limits the strobe to cycles in which the core reports an external move access. While an access to external data memory is in progress, the strobe of state 3 is dropped.

Top module: `clkmode_ale_top`

## Requirements
- R1: With the speed bit at 0, `core_en` is high on exactly one oscillator cycle out of two: 60 enables in any 120 consecutive oscillator cycles.
- R2: With the speed bit at 1, `core_en` is high on every oscillator cycle: 120 enables in 120 cycles.
- R3: While reset is asserted, `core_en`, `ale` and `phase` are 0 and standard speed is held. After reset, the block starts in standard speed.
- R4: A change of `x2_sel` takes effect only on an oscillator edge at which the internal halved clock rises. A switch to double speed therefore gives continuous enables within two oscillator cycles.
- R5: `phase` lies in the range 0 to 5. It advances by one, wrapping from 5 to 0, on each cycle in which `core_en` is high, and it holds otherwise.
- R6: `ale` is high only on a cycle where `core_en` is high and `phase` is 0 or 3. With no suppression, this gives 20 strobes per 120 oscillator cycles in standard speed and 40 in double speed.
- R7: With `ale_off` at 1, `ale` is low whenever `ext_access` is 0. With `ext_access` at 1, the strobe rate is the same as without suppression.
- R8: While `ext_data` is 1, the strobe at `phase` 3 is skipped, which halves the strobe count.
- R9: Each `ale` pulse is exactly one oscillator cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x2_sel | input | 1 | Speed bit: 0 standard (halved), 1 double speed |
| ale_off | input | 1 | 1 limits the strobe to external move accesses |
| ext_access | input | 1 | External move (data or code) access in progress |
| ext_data | input | 1 | External data memory access in progress |
| core_en | output | 1 | One-cycle core clock enable |
| phase | output | 3 | State within the machine cycle, 0 to 5 |
| ale | output | 1 | Address latch strobe |

## Verification
The bench sweeps all sixteen combinations of the speed bit, suppress bit, access flag and data-access flag. Over a 120-cycle window, a whole number of machine cycles in either speed, it counts enables and strobes. The enable count separates the two speeds. The strobe count separates the no-suppression case, the suppressed case without an access, the suppressed case with an access, and the halved rate of a data access. On every sampled cycle the bench also checks that the phase steps by one and that each strobe falls on state 0 or 3. A speed switch is checked for the number of cycles it takes to take effect, and a reset during a double-speed run is checked for a quiet output.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic {
    SPEED_STD = 1'b0,
    SPEED_DBL = 1'b1
  } speed_e;

  localparam int unsigned DEF_MC_STATES = 6;
endpackage

// File: rtl/clkmode_rst_sync.sv
module clkmode_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/clkmode_speed_sel.sv
module clkmode_speed_sel
  import clkmode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic x2_sel,
  output logic core_en
);
  logic   half_q, half_d;
  speed_e mode_q, mode_d;

  always_comb begin
    half_d = ~half_q;
    mode_d = mode_q;
    if (!half_q) mode_d = speed_e'(x2_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      mode_q <= SPEED_STD;
    end else begin
      half_q <= half_d;
      mode_q <= mode_d;
    end
  end

  assign core_en = (mode_q == SPEED_DBL) | half_q;

  AST_MODE_ON_DIV_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> half_q); // R4

  AST_STD_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && mode_q == SPEED_STD) |=> (!core_en || mode_q == SPEED_DBL)); // R1
endmodule

// File: rtl/clkmode_phase_ctr.sv
module clkmode_phase_ctr #(
  parameter int unsigned MC_STATES = 6,
  localparam int unsigned PW = $clog2(MC_STATES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_en,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(MC_STATES - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (core_en) begin
      if (phase_q == LAST) phase_d = '0;
      else                 phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST); // R5

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(phase_q)); // R5
endmodule

// File: rtl/clkmode_ale_gen.sv
module clkmode_ale_gen #(
  parameter int unsigned MC_STATES = 6,
  localparam int unsigned PW      = $clog2(MC_STATES),
  localparam int unsigned ALE_GAP = MC_STATES / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_en,
  input  logic [PW-1:0] phase,
  input  logic          ale_off,
  input  logic          ext_access,
  input  logic          ext_data,
  output logic          ale
);
  logic slot_first, slot_second, window_ok;

  always_comb begin
    slot_first  = (phase == '0);
    slot_second = (phase == PW'(ALE_GAP)) & ~ext_data;
    window_ok   = ~ale_off | ext_access;
    ale         = core_en & window_ok & (slot_first | slot_second);
  end

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R9
endmodule

// File: rtl/clkmode_ale_top.sv
module clkmode_ale_top
  import clkmode_pkg::*;
#(
  parameter int unsigned MC_STATES = DEF_MC_STATES,
  localparam int unsigned PW = $clog2(MC_STATES)
) (
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          x2_sel,
  input  logic          ale_off,
  input  logic          ext_access,
  input  logic          ext_data,
  output logic          core_en,
  output logic [PW-1:0] phase,
  output logic          ale
);
  logic rst_sn;

  clkmode_rst_sync #(.STAGES(2)) u_rst (
    .clk    (osc_clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  clkmode_speed_sel u_speed (
    .clk     (osc_clk),
    .rst_n   (rst_sn),
    .x2_sel  (x2_sel),
    .core_en (core_en)
  );

  clkmode_phase_ctr #(.MC_STATES(MC_STATES)) u_phase (
    .clk     (osc_clk),
    .rst_n   (rst_sn),
    .core_en (core_en),
    .phase   (phase)
  );

  clkmode_ale_gen #(.MC_STATES(MC_STATES)) u_ale (
    .clk        (osc_clk),
    .rst_n      (rst_sn),
    .core_en    (core_en),
    .phase      (phase),
    .ale_off    (ale_off),
    .ext_access (ext_access),
    .ext_data   (ext_data),
    .ale        (ale)
  );
endmodule

// File: tb/clkmode_ale_top_test.sv
module clkmode_ale_top_test;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x2_sel = 1'b0;
  logic       ale_off = 1'b0;
  logic       ext_access = 1'b0;
  logic       ext_data = 1'b0;
  logic       core_en;
  logic [2:0] phase;
  logic       ale;

  int n_checks = 0;
  int n_fail = 0;

  clkmode_ale_top uut (
    .osc_clk(osc_clk), .rst_n(rst_n), .x2_sel(x2_sel), .ale_off(ale_off),
    .ext_access(ext_access), .ext_data(ext_data),
    .core_en(core_en), .phase(phase), .ale(ale)
  );

  always #10 osc_clk = ~osc_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  // Count enables and strobes over n cycles; check phase steps and strobe slots.
  task automatic run_win(input int n, input int exp_en, input int exp_ale,
                         input string en_req, input string ale_req);
    int en_cnt = 0;
    int ale_cnt = 0;
    int prev = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge osc_clk);
      if (core_en) begin
        en_cnt++;
        if (prev >= 0) check(int'(phase) == (prev + 1) % 6, "R5 phase step", phase, (prev + 1) % 6);
        prev = phase;
      end
      if (ale) begin
        ale_cnt++;
        check(core_en && (phase == 0 || phase == 3), "R6 strobe slot", phase, 0);
      end
    end
    check(en_cnt == exp_en, en_req, en_cnt, exp_en);
    check(ale_cnt == exp_ale, ale_req, ale_cnt, exp_ale);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    int base;
    int exp_a;
    // R3: reset state
    idle(3);
    check(core_en == 0, "R3 reset core_en", core_en, 0);
    check(phase == 0, "R3 reset phase", phase, 0);
    check(ale == 0, "R3 reset ale", ale, 0);
    rst_n = 1'b1;
    idle(10);
    // R3: starts in standard speed
    run_win(120, 60, 20, "R3 std after reset", "R6 std strobe");

    for (int m = 0; m < 2; m++) begin
      if (m == 1) begin
        x2_sel = 1'b1;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
          @(negedge osc_clk);
          if (core_en) cnt++;
        end
        check(cnt >= 3, "R4 switch latency", cnt, 3);
        idle(20);
      end
      for (int k = 0; k < 8; k++) begin
        ale_off    = k[2];
        ext_access = k[1];
        ext_data   = k[0];
        idle(12);
        base = (m == 1) ? 40 : 20;
        if (ale_off && !ext_access) exp_a = 0;
        else if (ext_data)          exp_a = base / 2;
        else                        exp_a = base;
        run_win(120, (m == 1) ? 120 : 60, exp_a,
                (m == 1) ? "R2 dbl enables" : "R1 std enables",
                (ale_off && !ext_access) ? "R7 suppressed" :
                (ext_data ? "R8 data skip" : "R6 strobe rate"));
      end
    end

    // R9: strobe width in double speed, no suppression
    ale_off = 1'b0; ext_access = 1'b0; ext_data = 1'b0;
    idle(6);
    begin
      int last = 0;
      int wide = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge osc_clk);
        if (ale && last) wide++;
        last = ale;
      end
      check(wide == 0, "R9 one cycle strobe", wide, 0);
    end

    // R4: back to standard speed
    x2_sel = 1'b0;
    idle(24);
    run_win(120, 60, 20, "R4 std after switch", "R6 std strobe");

    // R3: reset in double speed quiets outputs
    x2_sel = 1'b1;
    idle(24);
    rst_n = 1'b0;
    idle(2);
    check(core_en == 0, "R3 reset mid-run core_en", core_en, 0);
    check(phase == 0, "R3 reset mid-run phase", phase, 0);
    check(ale == 0, "R3 reset mid-run ale", ale, 0);
    rst_n = 1'b1;
    idle(30);
    run_win(120, 120, 40, "R2 dbl after reset", "R6 dbl strobe");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule